// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is a fixed-coefficient FIR filter that uses no multipliers. It keeps the most recent samples in a tap register. For each output it walks through the sample bit positions, one position per clock. In every step it takes the same bit from each stored sample and uses those bits as an address into precomputed tables. Each table holds sums of subsets of the coefficients. The table results are weighted by powers of two and accumulated. The sign-bit step is subtracted, which gives two's complement arithmetic.

The coefficients are an elaboration-time parameter, and the table contents are computed from them during elaboration. To keep the tables small, the taps are grouped into partitions of `PART_TAPS` taps each. Each partition has its own table of 2^PART_TAPS entries, and the partition outputs for a bit step are added together. A parameter selects the order of the bit walk: least significant bit first with an arithmetic right shift, or most significant bit first with a left shift. Both orders give bit-exact results.

Samples enter through a valid/ready handshake, at most one every `SAMPLE_W` cycles. Each result appears on a registered output together with a one-cycle valid strobe.

Top module: `da_fir`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. Every stored tap is zero, so the first outputs see an all-zero history.
- R2: Each output equals the sum over k of c[k]·x[n−k], where x[n] is the newest accepted sample. Coefficient c[k] is the signed `COEF_W`-bit field at bits [k·COEF_W +: COEF_W] of `COEF_FLAT`. Samples and result are two's complement, and the result is exact at the full `OUT_W` width.
- R3: The sign bit of each sample carries negative weight, so sample value −2^(SAMPLE_W−1) (−128 at default width) filters correctly, both in a single tap and in every tap.
- R4: When a sample is accepted at rising edge E, `out_valid` is driven high by rising edge E+SAMPLE_W. It stays high for exactly one cycle.
- R5: `in_ready` is 1 while the block is idle. While a result is being computed, `in_ready` is 1 only in the final bit-step cycle. Under a continuous supply, samples are therefore accepted exactly every `SAMPLE_W` cycles, with `in_ready` low for `SAMPLE_W`−1 cycles between acceptances.
- R6: A sample offered (`in_valid`=1) while `in_ready`=0 is ignored. The tap register does not change, and later outputs are the same as if that sample had never been offered.
- R7: Between strobes, `out_data` holds the last result. No strobe occurs unless a sample was accepted.
- R8: Results are identical for any partition size that divides `NTAPS`, and for either bit-walk order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | SAMPLE_W | Two's complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | OUT_W | Two's complement filter result |

## Verification
A lone unit sample followed by zeros reads the coefficients back one at a time. This separates tap ordering and coefficient placement from the accumulation itself. Runs built from the most negative sample, alone and filling every tap, isolate the subtraction of the sign step. A pattern whose signs follow the coefficient signs drives the result close to its largest magnitude and exposes any width that is too narrow. Pseudo-random streams sent back to back, and streams where junk samples are offered while the block is busy, check general correctness, handshake pacing and rejection. A second instance with smaller partitions and the opposite bit order must produce the same values.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

   typedef enum logic {
      ORDER_LSB_FIRST = 1'b0,
      ORDER_MSB_FIRST = 1'b1
   } slice_order_e;

endpackage

// File: rtl/da_part_rom.sv
module da_part_rom #(
   parameter int PART_TAPS = 4,
   parameter int COEF_W    = 8,
   parameter int TAB_W     = 11,
   parameter logic [PART_TAPS*COEF_W-1:0] PART_COEFS = '0
) (
   input  logic [PART_TAPS-1:0]    addr,
   output logic signed [TAB_W-1:0] entry
);
   localparam int DEPTH = 1 << PART_TAPS;

   function automatic int subset_sum(input int sel);
      int acc;
      acc = 0;
      for (int k = 0; k < PART_TAPS; k++) begin
         if (((sel >> k) & 1) != 0)
            acc += int'($signed(PART_COEFS[k*COEF_W +: COEF_W]));
      end
      return acc;
   endfunction

   logic signed [TAB_W-1:0] table_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      assign table_q[e] = TAB_W'(subset_sum(e));
   end

   assign entry = table_q[addr];
endmodule

// File: rtl/da_slice_adder.sv
module da_slice_adder #(
   parameter int NTAPS     = 8,
   parameter int PART_TAPS = 4,
   parameter int COEF_W    = 8,
   parameter int SUM_W     = 12,
   parameter logic [NTAPS*COEF_W-1:0] COEF_FLAT = '0
) (
   input  logic [NTAPS-1:0]        slice_bits,
   output logic signed [SUM_W-1:0] slice_sum
);
   localparam int NPART = NTAPS / PART_TAPS;
   localparam int TAB_W = COEF_W + $clog2(PART_TAPS) + 1;

   logic signed [TAB_W-1:0] part_out [NPART];

   for (genvar g = 0; g < NPART; g++) begin : g_part
      da_part_rom #(
         .PART_TAPS (PART_TAPS),
         .COEF_W    (COEF_W),
         .TAB_W     (TAB_W),
         .PART_COEFS(COEF_FLAT[g*PART_TAPS*COEF_W +: PART_TAPS*COEF_W])
      ) i_rom (
         .addr (slice_bits[g*PART_TAPS +: PART_TAPS]),
         .entry(part_out[g])
      );
   end

   always_comb begin
      slice_sum = '0;
      for (int g = 0; g < NPART; g++)
         slice_sum += SUM_W'(part_out[g]);
   end
endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc import da_fir_pkg::*; #(
   parameter int           SAMPLE_W = 8,
   parameter int           SUM_W    = 12,
   parameter int           OUT_W    = 20,
   parameter slice_order_e ORDER    = ORDER_LSB_FIRST
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    busy,
   input  logic                    first,
   input  logic                    sign_step,
   input  logic signed [SUM_W-1:0] slice_sum,
   output logic signed [OUT_W-1:0] acc_next
);
   logic signed [OUT_W-1:0] acc_q;
   logic signed [OUT_W-1:0] term;

   always_comb begin
      term = sign_step ? -OUT_W'(slice_sum) : OUT_W'(slice_sum);
   end

   if (ORDER == ORDER_LSB_FIRST) begin : g_lsb
      logic signed [OUT_W-1:0] term_hi;
      always_comb begin
         term_hi  = term <<< (SAMPLE_W - 1);
         acc_next = first ? term_hi : (acc_q >>> 1) + term_hi;
      end

      // Every discarded bit must be zero for the result to stay exact.
      AST_EXACT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
         (busy && !first) |-> (acc_q[0] == 1'b0)); // R8
   end else begin : g_msb
      always_comb begin
         acc_next = first ? term : (acc_q <<< 1) + term;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (busy)
         acc_q <= acc_next;
   end
endmodule

// File: rtl/da_seq_ctrl.sv
module da_seq_ctrl #(
   parameter int SAMPLE_W = 8,
   parameter int CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             take,
   output logic             busy,
   output logic             first,
   output logic             last,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

   always_comb begin
      last     = busy && (cnt == CNT_LAST);
      first    = busy && (cnt == '0);
      in_ready = !busy || last;
      take     = in_valid && in_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (take) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (last) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (busy && cnt == '0)); // R5

   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !in_ready) |=> (busy && cnt == $past(cnt) + CNT_W'(1))); // R5

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_LAST); // R5
endmodule

// File: rtl/da_fir.sv
module da_fir import da_fir_pkg::*; #(
   parameter int           NTAPS     = 8,
   parameter int           SAMPLE_W  = 8,
   parameter int           COEF_W    = 8,
   parameter int           PART_TAPS = 4,
   parameter logic [NTAPS*COEF_W-1:0] COEF_FLAT = 64'h09FF_2D80_7F14_F903,
   parameter slice_order_e ORDER     = ORDER_LSB_FIRST,
   parameter int           OUT_W     = COEF_W + SAMPLE_W + $clog2(NTAPS) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                out_valid,
   output logic [OUT_W-1:0]    out_data
);
   localparam int CNT_W = $clog2(SAMPLE_W);
   localparam int SUM_W = COEF_W + $clog2(NTAPS) + 1;
   localparam int MIN_W = SUM_W + SAMPLE_W - 1;

   if (NTAPS % PART_TAPS != 0) begin : g_bad_part
      $error("PART_TAPS must divide NTAPS");
   end
   if (PART_TAPS < 1 || PART_TAPS > 10) begin : g_bad_size
      $error("PART_TAPS must lie in 1..10");
   end
   if (SAMPLE_W < 2) begin : g_bad_sw
      $error("SAMPLE_W must be at least 2");
   end
   if (COEF_W < 2 || COEF_W > 24) begin : g_bad_cw
      $error("COEF_W must lie in 2..24");
   end
   if (OUT_W < MIN_W) begin : g_bad_ow
      $error("OUT_W too narrow for the worst-case result");
   end

   logic                    take, busy, first, last;
   logic [CNT_W-1:0]        cnt;
   logic [CNT_W-1:0]        bit_idx;
   logic                    sign_step;
   logic [NTAPS-1:0][SAMPLE_W-1:0] taps_q;
   logic [NTAPS-1:0]        slice_bits;
   logic signed [SUM_W-1:0] slice_sum;
   logic signed [OUT_W-1:0] acc_next;

   da_seq_ctrl #(
      .SAMPLE_W(SAMPLE_W),
      .CNT_W   (CNT_W)
   ) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .in_ready(in_ready),
      .take    (take),
      .busy    (busy),
      .first   (first),
      .last    (last),
      .cnt     (cnt)
   );

   if (ORDER == ORDER_LSB_FIRST) begin : g_idx_lsb
      assign bit_idx   = cnt;
      assign sign_step = last;
   end else begin : g_idx_msb
      assign bit_idx   = CNT_W'(SAMPLE_W - 1) - cnt;
      assign sign_step = first;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taps_q <= '0;
      end else if (take) begin
         taps_q[0] <= in_data;
         for (int t = 1; t < NTAPS; t++)
            taps_q[t] <= taps_q[t-1];
      end
   end

   always_comb begin
      for (int t = 0; t < NTAPS; t++)
         slice_bits[t] = taps_q[t][bit_idx];
   end

   da_slice_adder #(
      .NTAPS    (NTAPS),
      .PART_TAPS(PART_TAPS),
      .COEF_W   (COEF_W),
      .SUM_W    (SUM_W),
      .COEF_FLAT(COEF_FLAT)
   ) i_slice (
      .slice_bits(slice_bits),
      .slice_sum (slice_sum)
   );

   da_shift_acc #(
      .SAMPLE_W(SAMPLE_W),
      .SUM_W   (SUM_W),
      .OUT_W   (OUT_W),
      .ORDER   (ORDER)
   ) i_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .first    (first),
      .sign_step(sign_step),
      .slice_sum(slice_sum),
      .acc_next (acc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= last;
         if (last)
            out_data <= acc_next;
      end
   end

   AST_TAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> $stable(taps_q)); // R6

   AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R4

   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data)); // R7

   AST_STROBE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(busy)); // R7
endmodule

// File: tb/test_da_fir.sv
module test_da_fir;
   import da_fir_pkg::*;

   localparam int NT   = 8;
   localparam int SW   = 8;
   localparam int CW   = 8;
   localparam int OW   = CW + SW + $clog2(NT) + 1;
   localparam logic [NT*CW-1:0] CFLAT = 64'h09FF_2D80_7F14_F903;
   localparam int MAXQ = 512;

   // c[k] placed at bits [k*8 +: 8] of CFLAT
   int coef_tb [NT] = '{3, -7, 20, 127, -128, 45, -1, 9};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [SW-1:0] in_data = '0;
   logic in_ready, in_ready_b;
   logic out_valid, out_valid_b;
   logic [OW-1:0] out_data, out_data_b;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   longint hist [NT];
   longint exp_q [MAXQ];
   int     acc_edge [MAXQ];
   int     wr = 0, rd_a = 0, rd_b = 0;
   bit     prev_a = 1'b0, prev_b = 1'b0;
   int     last_edge = 0;
   int     last_wait = 0;
   int unsigned lfsr = 32'h1234_5679;

   always #5 clk = ~clk;

   da_fir #(.NTAPS(NT), .SAMPLE_W(SW), .COEF_W(CW), .PART_TAPS(4),
            .COEF_FLAT(CFLAT), .ORDER(ORDER_LSB_FIRST)) i_da_fir (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

   da_fir #(.NTAPS(NT), .SAMPLE_W(SW), .COEF_W(CW), .PART_TAPS(2),
            .COEF_FLAT(CFLAT), .ORDER(ORDER_MSB_FIRST)) i_da_fir_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
      .in_data(in_data), .out_valid(out_valid_b), .out_data(out_data_b));

   task automatic check(input string tag, input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic longint model();
      longint s = 0;
      for (int k = 0; k < NT; k++) s += longint'(coef_tb[k]) * hist[k];
      return s;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   // output monitor, both instances
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (rd_a >= wr) check("R7 strobe without sample (a)", 1, 0);
            else begin
               check("R2 result (a)", longint'($signed(out_data)), exp_q[rd_a]);
               check("R4 latency (a)", longint'(cyc), longint'(acc_edge[rd_a] + SW));
               rd_a++;
            end
            if (prev_a) check("R4 pulse width (a)", 2, 1);
         end
         if (out_valid_b) begin
            if (rd_b >= wr) check("R7 strobe without sample (b)", 1, 0);
            else begin
               check("R8 result alt variant", longint'($signed(out_data_b)), exp_q[rd_b]);
               rd_b++;
            end
            if (prev_b) check("R4 pulse width (b)", 2, 1);
         end
         prev_a = out_valid;
         prev_b = out_valid_b;
      end
   end

   // starts and ends at a falling edge
   task automatic push(input logic [SW-1:0] x);
      int waits = 0;
      in_valid = 1'b1;
      in_data  = x;
      while (!in_ready) begin
         waits++;
         @(negedge clk);
      end
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'($signed(x));
      exp_q[wr]    = model();
      acc_edge[wr] = cyc + 1;
      last_edge    = cyc + 1;
      last_wait    = waits;
      wr++;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (SW + 3) @(negedge clk);
      check("R7 all outputs seen (a)", rd_a, wr);
      check("R8 all outputs seen (b)", rd_b, wr);
   endtask

   task automatic t_reset();
      check("R1 out_valid after reset", out_valid, 0);
      check("R1 out_data after reset", longint'(out_data), 0);
      check("R1 in_ready after reset", in_ready, 1);
   endtask

   task automatic t_impulse();
      push(8'd1);
      for (int i = 0; i < NT; i++) push(8'd0);
      drain();
   endtask

   task automatic t_most_negative();
      push(8'h80);
      for (int i = 0; i < NT; i++) push(8'd0);
      for (int i = 0; i < NT + 2; i++) push(8'h80);
      drain();
      check("R3 full-scale negative result", longint'($signed(out_data)), -128 * 68);
   endtask

   task automatic t_extreme();
      for (int i = 0; i < NT; i++) push((coef_tb[NT-1-i] < 0) ? 8'h80 : 8'h7F);
      drain();
      for (int i = 0; i < NT; i++) push((coef_tb[NT-1-i] < 0) ? 8'h7F : 8'h80);
      drain();
   endtask

   task automatic t_stream();
      int prev_edge;
      push(8'd17);
      for (int i = 0; i < 40; i++) begin
         prev_edge = last_edge;
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         push(lfsr[SW-1:0]);
         if (i % 8 == 0) begin
            check("R5 accept spacing", last_edge - prev_edge, SW);
            check("R5 ready low cycles", last_wait, SW - 1);
         end
      end
      drain();
   endtask

   task automatic t_ignore();
      push(8'd5);
      for (int i = 0; i < 6; i++) begin
         in_valid = 1'b1;
         in_data  = 8'h7B;
         while (!in_ready) @(negedge clk);
         push(8'(i * 37 - 90));
      end
      drain();
      check("R6 junk never reached taps", longint'($signed(out_data)), exp_q[wr-1]);
   endtask

   task automatic t_idle_hold();
      logic [OW-1:0] held;
      int seen;
      held = out_data;
      seen = rd_a;
      for (int i = 0; i < 4 * SW; i++) begin
         in_data = 8'(i * 11);
         @(negedge clk);
      end
      check("R7 no strobe while idle", rd_a, seen);
      check("R7 out_data held", longint'(out_data), longint'(held));
      check("R5 ready while idle", in_ready, 1);
   endtask

   initial begin
      for (int k = 0; k < NT; k++) hist[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_impulse();
      t_most_negative();
      t_extreme();
      t_stream();
      t_ignore();
      t_idle_hold();
      finish_run();
   end
endmodule